// File: doc/BRIEF.md
# Packed Saturating Add-Subtract Unit

This block performs lane-parallel integer arithmetic on two 64-bit operands. A two-bit width code splits each operand into eight 8-bit, four 16-bit or two 32-bit lanes. A three-bit operation code selects one of three kinds of work for every lane at once:

- add or subtract;
- an equality compare;
- a signed greater-than compare.

Add and subtract each come in three flavours: modular, signed clamping and unsigned clamping. Carries never cross a lane boundary, so each lane behaves like an independent adder with its own limits.

The datapath is combinational. A parameter either places a valid-qualified output register after it or leaves the outputs combinational. An operation and width pair that has no meaning returns an all-zero result and raises an illegal flag. A surrounding execution pipeline feeds the block from its own register file and collects the result.

Top module: `psat_addsub`

## Requirements
- R1: Width code 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes and 2 gives two 32-bit lanes. Lane i occupies bits i*LW to i*LW+LW-1. No carry or borrow crosses a lane boundary.
- R2: Op 0 returns A+B and op 3 returns A-B in every lane, both modulo 2^LW, for all three legal widths.
- R3: Op 1 (signed clamping add) and op 4 (signed clamping subtract) saturate out-of-range values. For 8-bit lanes the limits are 0x7F and 0x80. For 16-bit lanes the limits are 0x7FFF and 0x8000.
- R4: Op 2 (unsigned clamping add) returns 0xFF for an 8-bit lane that would exceed its range, and 0xFFFF for a 16-bit lane.
- R5: Op 5 (unsigned clamping subtract) returns zero for any lane where B is greater than A, at 8 and 16 bits.
- R6: Op 6 fills a lane with all ones when the A and B lanes are equal, and with all zeros otherwise.
- R7: Op 7 fills a lane with all ones when the A lane is greater than the B lane as signed two's complement, and with all zeros otherwise.
- R8: Width code 3, or any clamping op (1, 2, 4, 5) with width code 2, returns a zero result with the illegal flag set. Every other legal pair returns the flag clear.
- R9: With the output register enabled, result and illegal flag appear one clock after in_valid is high, and out_valid follows in_valid by one clock. When in_valid is low, the registered result does not change.
- R10: While reset is asserted, out_valid, the result and the illegal flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and codes are valid this cycle |
| op_i | input | 3 | Operation code (0 add, 1 signed clamp add, 2 unsigned clamp add, 3 sub, 4 signed clamp sub, 5 unsigned clamp sub, 6 equal, 7 signed greater) |
| width_i | input | 2 | Lane width code (0: 8, 1: 16, 2: 32, 3: illegal) |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| out_valid | output | 1 | Result valid |
| result_o | output | 64 | Lane-wise result |
| illegal_o | output | 1 | Operation and width pair not supported |

## Verification
Some properties are checked on every cycle:

- the one-cycle valid latency and the hold of the result while in_valid is low;
- the zero result of an illegal pair;
- compare outputs made only of whole 0x00 or 0xFF bytes;
- a lane that saturated showing a value from the limit set of the selected op.

The bench's sweeps alone can show the exact lane values: correct wrap-around, the precise clamp point, signed versus unsigned ordering, and the absence of carry leakage between lanes. The bench computes these arithmetically in wide integers for every op and width.

// File: rtl/psat_pkg.sv
package psat_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDS = 3'd1,
    OP_ADDU = 3'd2,
    OP_SUB  = 3'd3,
    OP_SUBS = 3'd4,
    OP_SUBU = 3'd5,
    OP_CEQ  = 3'd6,
    OP_CGT  = 3'd7
  } psat_op_e;

  typedef enum logic [1:0] {
    LW_B8  = 2'd0,
    LW_B16 = 2'd1,
    LW_B32 = 2'd2,
    LW_BAD = 2'd3
  } psat_lw_e;

  localparam int unsigned NUM_WIDTHS = 3;

  function automatic logic is_clamp_op(psat_op_e op);
    return (op == OP_ADDS) || (op == OP_ADDU) || (op == OP_SUBS) || (op == OP_SUBU);
  endfunction

  function automatic logic is_cmp_op(psat_op_e op);
    return (op == OP_CEQ) || (op == OP_CGT);
  endfunction

endpackage

// File: rtl/psat_lane.sv
module psat_lane
  import psat_pkg::*;
#(
  parameter int unsigned LW = 8
) (
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  input  psat_op_e      op_i,
  output logic [LW-1:0] res_o,
  output logic          sat_o
);

  localparam logic [LW-1:0] S_MAX = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] S_MIN = {1'b1, {(LW-1){1'b0}}};

  // signed add/sub on LW+1 bits; top bit of the return is the clamp event
  function automatic logic [LW:0] f_signed(logic [LW-1:0] a, logic [LW-1:0] b, logic sub);
    logic [LW:0] ext;
    logic        ovf;
    ext = sub ? ({a[LW-1], a} - {b[LW-1], b}) : ({a[LW-1], a} + {b[LW-1], b});
    ovf = ext[LW] ^ ext[LW-1];
    if (ovf) return {1'b1, (ext[LW] ? S_MIN : S_MAX)};
    return {1'b0, ext[LW-1:0]};
  endfunction

  // unsigned add/sub; carry or borrow out forces the limit
  function automatic logic [LW:0] f_unsigned(logic [LW-1:0] a, logic [LW-1:0] b, logic sub);
    logic [LW:0] ext;
    ext = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    if (ext[LW]) return {1'b1, (sub ? {LW{1'b0}} : {LW{1'b1}})};
    return {1'b0, ext[LW-1:0]};
  endfunction

  logic [LW:0] s_add, s_sub, u_add, u_sub;

  assign s_add = f_signed(a_i, b_i, 1'b0);
  assign s_sub = f_signed(a_i, b_i, 1'b1);
  assign u_add = f_unsigned(a_i, b_i, 1'b0);
  assign u_sub = f_unsigned(a_i, b_i, 1'b1);

  always_comb begin
    res_o = '0;
    sat_o = 1'b0;
    case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_ADDS: {sat_o, res_o} = s_add;
      OP_SUBS: {sat_o, res_o} = s_sub;
      OP_ADDU: {sat_o, res_o} = u_add;
      OP_SUBU: {sat_o, res_o} = u_sub;
      OP_CEQ:  res_o = (a_i == b_i) ? '1 : '0;
      OP_CGT:  res_o = ($signed(a_i) > $signed(b_i)) ? '1 : '0;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/psat_slice.sv
module psat_slice
  import psat_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned LW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  psat_op_e      op_i,
  output logic [DW-1:0] res_o,
  output logic          sat_any_o
);

  localparam int unsigned NL = DW / LW;

  logic [NL-1:0] lane_sat;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    psat_lane #(.LW(LW)) u_lane (
      .a_i   (a_i[l*LW +: LW]),
      .b_i   (b_i[l*LW +: LW]),
      .op_i  (op_i),
      .res_o (res_o[l*LW +: LW]),
      .sat_o (lane_sat[l])
    );
  end

  assign sat_any_o = |lane_sat;

endmodule

// File: rtl/psat_decode.sv
module psat_decode
  import psat_pkg::*;
(
  input  psat_op_e op_i,
  input  psat_lw_e width_i,
  output logic     illegal_o
);

  always_comb begin
    case (width_i)
      LW_B8, LW_B16: illegal_o = 1'b0;
      LW_B32:        illegal_o = is_clamp_op(op_i);
      default:       illegal_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/psat_addsub.sv
module psat_addsub
  import psat_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned LANE_MIN = 8,
  parameter bit          REG_OUT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_i,
  input  logic [1:0]        width_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              out_valid,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);

  localparam int unsigned NBYTES = DATA_W / 8;

  psat_op_e          op_e;
  psat_lw_e          lw_e;
  logic              dec_illegal;
  logic [DATA_W-1:0] slice_res [NUM_WIDTHS];
  logic              slice_sat [NUM_WIDTHS];
  logic [DATA_W-1:0] comb_res;
  logic              comb_sat;   // a lane of the selected width hit a limit

  assign op_e = psat_op_e'(op_i);
  assign lw_e = psat_lw_e'(width_i);

  psat_decode u_decode (
    .op_i      (op_e),
    .width_i   (lw_e),
    .illegal_o (dec_illegal)
  );

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    psat_slice #(.DW(DATA_W), .LW(LANE_MIN << g)) u_slice (
      .a_i       (a_i),
      .b_i       (b_i),
      .op_i      (op_e),
      .res_o     (slice_res[g]),
      .sat_any_o (slice_sat[g])
    );
  end

  always_comb begin
    comb_res = '0;
    comb_sat = 1'b0;
    if (!dec_illegal) begin
      for (int g = 0; g < NUM_WIDTHS; g++) begin
        if (width_i == 2'(g)) begin
          comb_res = slice_res[g];
          comb_sat = slice_sat[g];
        end
      end
    end
  end

  function automatic logic has_byte(logic [DATA_W-1:0] v, logic [7:0] x);
    for (int i = 0; i < NBYTES; i++) if (v[i*8 +: 8] == x) return 1'b1;
    return 1'b0;
  endfunction

  if (REG_OUT) begin : g_reg
    logic              q_vld, q_ill, q_sat;
    logic [DATA_W-1:0] q_res;
    psat_op_e          q_op;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_vld <= 1'b0;
        q_ill <= 1'b0;
        q_sat <= 1'b0;
        q_res <= '0;
        q_op  <= OP_ADD;
      end else begin
        q_vld <= in_valid;
        if (in_valid) begin
          q_ill <= dec_illegal;
          q_sat <= comb_sat;
          q_res <= comb_res;
          q_op  <= op_e;
        end
      end
    end

    assign out_valid = q_vld;
    assign result_o  = q_res;
    assign illegal_o = q_ill;

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) // R9
      in_valid |=> out_valid);
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n) // R9
      !in_valid |=> !out_valid);
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) // R9
      !in_valid |=> $stable(result_o) && $stable(illegal_o));
    AST_BAD_WIDTH_FLAG: assert property (@(posedge clk) disable iff (!rst_n) // R8
      (in_valid && width_i == 2'd3) |=> illegal_o);
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) // R8
      illegal_o |-> (result_o == '0));
    AST_SIGNED_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) // R3
      (out_valid && q_sat && (q_op == OP_ADDS || q_op == OP_SUBS))
        |-> (has_byte(result_o, 8'h7F) || has_byte(result_o, 8'h80)));
    AST_UADD_CEIL: assert property (@(posedge clk) disable iff (!rst_n) // R4
      (out_valid && q_sat && q_op == OP_ADDU) |-> has_byte(result_o, 8'hFF));
    AST_USUB_FLOOR: assert property (@(posedge clk) disable iff (!rst_n) // R5
      (out_valid && q_sat && q_op == OP_SUBU) |-> has_byte(result_o, 8'h00));

    for (genvar k = 0; k < NBYTES; k++) begin : g_cmp_chk
      AST_CMP_WHOLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n) // R6
        (out_valid && !illegal_o && is_cmp_op(q_op))
          |-> (result_o[k*8 +: 8] == 8'h00 || result_o[k*8 +: 8] == 8'hFF));
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result_o  = comb_res;
    assign illegal_o = dec_illegal;
  end

endmodule

// File: tb/psat_addsub_bench.sv
`timescale 1ns/1ps
module psat_addsub_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  width = '0;
  logic [63:0] a = '0, b = '0;
  logic        out_valid, illegal;
  logic [63:0] result;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  psat_addsub u_psat_addsub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op), .width_i(width),
    .a_i(a), .b_i(b), .out_valid(out_valid), .result_o(result), .illegal_o(illegal)
  );

  function automatic bit ref_illegal(int o, int w);
    return (w == 3) || (w == 2 && (o == 1 || o == 2 || o == 4 || o == 5));
  endfunction

  function automatic logic [63:0] ref_vec(int o, int w, logic [63:0] x, logic [63:0] y);
    logic [63:0] res;
    int lw, nl;
    longint full, mask, half, ua, ub, sa, sb, r;
    res = '0;
    if (ref_illegal(o, w)) return res;
    lw = 8 << w;
    nl = 64 / lw;
    full = longint'(1) << lw;
    mask = full - 1;
    half = full / 2;
    for (int i = 0; i < nl; i++) begin
      ua = longint'(x >> (i * lw)) & mask;
      ub = longint'(y >> (i * lw)) & mask;
      sa = (ua >= half) ? ua - full : ua;
      sb = (ub >= half) ? ub - full : ub;
      case (o)
        0: r = ua + ub;
        1: begin r = sa + sb; if (r > half - 1) r = half - 1; if (r < -half) r = -half; end
        2: begin r = ua + ub; if (r > mask) r = mask; end
        3: r = ua - ub;
        4: begin r = sa - sb; if (r > half - 1) r = half - 1; if (r < -half) r = -half; end
        5: r = (ua >= ub) ? ua - ub : 0;
        6: r = (ua == ub) ? mask : 0;
        default: r = (sa > sb) ? mask : 0;
      endcase
      res = res | (64'(r & mask) << (i * lw));
    end
    return res;
  endfunction

  function automatic string req_of(int o, int w);
    if (ref_illegal(o, w)) return "R8";
    case (o)
      0, 3: return "R2";
      1, 4: return "R3";
      2: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (op=%0d w=%0d a=%h b=%h)", req, act, exp, op, width, a, b);
    end
  endtask

  // drive one vector at a falling edge, compare one cycle later
  task automatic run_vec(int o, int w, logic [63:0] x, logic [63:0] y);
    @(negedge clk);
    in_valid = 1'b1; op = 3'(o); width = 2'(w); a = x; b = y;
    @(negedge clk);
    check(req_of(o, w), result, ref_vec(o, w, x, y));
    check(ref_illegal(o, w) ? "R8" : "R8_flag", 64'(illegal), 64'(ref_illegal(o, w)));
    check("R9", 64'(out_valid), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] pa, pb, held;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", {out_valid, illegal, 62'd0}, 64'd0);
    check("R10", result, 64'd0);
    @(negedge clk) rst_n = 1'b1;

    // R1: a carry out of byte 0 must not reach byte 1
    run_vec(0, 0, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001);
    check("R1", result, 64'd0);
    run_vec(3, 1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001);
    check("R1", result, 64'h0000_0000_0000_FFFF);
    run_vec(0, 2, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001);
    check("R1", result, 64'd0);

    // directed clamp points
    run_vec(1, 0, 64'h7F7F_7F7F_8080_8080, 64'h0101_0101_FFFF_FFFF);
    check("R3", result, 64'h7F7F_7F7F_8080_8080);
    run_vec(1, 1, 64'h7FFF_8000_0001_FFFF, 64'h0001_FFFF_7FFF_8000);
    check("R3", result, 64'h7FFF_8000_7FFF_8000);
    run_vec(2, 1, 64'hFFFF_0001_8000_0000, 64'h0001_FFFF_8000_0000);
    check("R4", result, 64'hFFFF_FFFF_FFFF_0000);
    run_vec(5, 0, 64'h0010_2000_0000_0005, 64'h0020_1001_0000_0006);
    check("R5", result, 64'h0000_1000_0000_0000);
    run_vec(7, 0, 64'h80_7F_00_FF_01_00_05_05, 64'h7F_80_FF_00_00_01_05_04);
    check("R7", result, 64'h00_FF_FF_00_FF_00_00_FF);

    // sweeps over every op and legal width
    for (int w = 0; w < 3; w++) begin
      for (int o = 0; o < 8; o++) begin
        for (int k = 0; k < 256; k++) begin
          for (int j = 0; j < 8; j++) begin
            pa[j*8 +: 8] = 8'(k ^ (j * 37));
            pb[j*8 +: 8] = 8'((k * 11) + (j * 73));
          end
          if (o == 6 && (k % 4 == 0)) pb = pa;
          run_vec(o, w, pa, pb);
        end
        for (int k = 0; k < 48; k++) begin
          pa = {$urandom, $urandom};
          pb = (k % 3 == 0) ? {pa[63:32], $urandom} : {$urandom, $urandom};
          run_vec(o, w, pa, pb);
        end
      end
    end

    // R8: unsupported pairs
    for (int o = 0; o < 8; o++) run_vec(o, 3, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F);
    run_vec(2, 2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    check("R8", {63'd0, illegal}, 64'd1);

    // R9: idle cycle leaves the registered result alone
    run_vec(0, 0, 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010);
    held = result;
    @(negedge clk);
    in_valid = 1'b0; op = 3'd3; a = '1; b = 64'h5;
    @(negedge clk);
    check("R9", result, held);
    check("R9", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule